// File: doc/BRIEF.md
# Banked Interrupt Aggregator

This block gathers a parameterised number of interrupt request lines, grouped into banks of 32, and presents them to software through a flat set of 32-bit registers reached with a read strobe, a write strobe, a word address and write data. Every line has a latched raw status bit, an enable bit, and a detection-type bit that picks level or rising-edge capture. Enables are set and cleared through two separate write-one registers, so software never needs a read-modify-write to change one line.

Each bank reports its pending lines, meaning raw status ANDed with enable. One registered interrupt output leaves the block. It is asserted only when the global master enable is on, the separate output enable is on, and at least one enabled line is pending. Software can drop the output enable while it handles the interrupt and raise it again afterwards. Pending state is kept the whole time, so the output comes back if work remains.

Global registers sit at word addresses 0 to 3. Bank b occupies eight words starting at 16 + 8·b. Reads are combinational and qualified by the read strobe. Writes take effect at the next clock edge.

Top module: `bank_irq_ctrl`

## Requirements
- R1: A read of address 0 returns the line count NUM_LINES in bits 15:0 and VERSION in bits 31:16. NUM_LINES is a nonzero multiple of 32, and VERSION is neither 0 nor 16'hFFFF.
- R2: Bank word 0 is the enable-set register. Writing 1 to a bit enables that line, 0 bits leave the line unchanged, and a read returns the bank's enable mask. All enables are 0 after reset.
- R3: Bank word 1 is the enable-clear register. Writing 1 to a bit disables that line, 0 bits leave the line unchanged, and a read returns the enable mask.
- R4: A line whose type bit is 0 (level, the reset value) latches raw status while its input is high. The bit stays set after the input falls until software writes 1 to it in bank word 2. A read of word 2 returns the raw status.
- R5: Bank word 3 holds the type bits (read/write). A line with type 1 latches raw status only on a rising edge of its input, so clearing it while the input stays high leaves it clear.
- R6: When a line's set condition and a raw-clear write to that line fall in the same cycle, the line stays set.
- R7: Bank word 4 reads raw status ANDed with enable for that bank. Writes to word 4 have no effect.
- R8: Address 1 bit 0 is the master enable (reset 0). Address 2 bit 0 reads 1 exactly when the master enable is set and any enabled line is pending.
- R9: Address 3 bit 0 is the output enable (reset 1). The output irqOut is high in the cycle after master enable, output enable and any pending enabled line are all true. Clearing the output enable drops irqOut without changing raw status, and setting it again re-asserts irqOut while status is still pending.
- R10: Writes to bank addresses beyond the last bank have no effect, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe; read data is 0 when low |
| addr | input | ADDR_W | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data |
| irqIn | input | NUM_LINES | Interrupt request lines |
| irqOut | output | 1 | Registered aggregate interrupt |

## Verification
A behavioural model of every line, written per bit, runs alongside the design. The irqOut output is compared against this model on every clock, and every register read is compared against it. Level stimulus is a short pulse that then falls, which separates latching from plain pass-through. Edge stimulus is an input held high across a clear, which separates level capture from rising-edge capture. A set event and a clear are made to coincide, and lines in both banks are used, one with an enable and one without, to show which bank a write reaches. The output enable is toggled while status is pending, which separates masking of the output from loss of status. Writes to an address past the last bank are followed by readback of the real banks.

// File: rtl/bank_irq_pkg.sv
package bank_irq_pkg;
  localparam int LINES_PER_BANK = 32;
  localparam int BANK_IDX_W     = 8;
  localparam int GLOBAL_SPAN    = 16;
  localparam int BANK_STRIDE    = 8;

  // global word addresses
  localparam int A_IDENT  = 0;
  localparam int A_MASTER = 1;
  localparam int A_MSTAT  = 2;
  localparam int A_OUTEN  = 3;

  // per-bank word offsets
  localparam int S_EN_SET  = 0;
  localparam int S_EN_CLR  = 1;
  localparam int S_RAW     = 2;
  localparam int S_TYPE    = 3;
  localparam int S_PENDING = 4;

  typedef struct packed {
    logic                  masterWr;
    logic                  outEnWr;
    logic                  enSetWr;
    logic                  enClrWr;
    logic                  rawClrWr;
    logic                  typeWr;
    logic [BANK_IDX_W-1:0] bank;
  } ctlStrobes_t;
endpackage

// File: rtl/bank_irq_decode.sv
module bank_irq_decode
  import bank_irq_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 8,
  parameter logic [15:0] VERSION = 16'h0102
) (
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_LINES-1:0] en,
  input  logic [NUM_LINES-1:0] raw,
  input  logic [NUM_LINES-1:0] typ,
  input  logic                 masterEn,
  input  logic                 outEn,
  input  logic                 anyPending,
  output ctlStrobes_t          strb,
  output logic [31:0]          rdData
);
  localparam int NUM_BANKS = NUM_LINES / LINES_PER_BANK;
  localparam int BIDX_W    = ADDR_W - 3;
  localparam logic [BIDX_W-1:0] BANK_LIM = BIDX_W'(NUM_BANKS);

  logic              isGlobal;
  logic              inRange;
  logic [ADDR_W-1:0] off;
  logic [BIDX_W-1:0] bIdx;
  logic [2:0]        sub;
  logic [31:0]       enB, rawB, typB;

  always_comb begin
    isGlobal = addr < ADDR_W'(GLOBAL_SPAN);
    off      = addr - ADDR_W'(GLOBAL_SPAN);
    bIdx     = off[ADDR_W-1:3];
    sub      = off[2:0];
    inRange  = !isGlobal && (bIdx < BANK_LIM);
    enB  = '0;
    rawB = '0;
    typB = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bIdx == BIDX_W'(b)) begin
        enB  = en[b*LINES_PER_BANK +: LINES_PER_BANK];
        rawB = raw[b*LINES_PER_BANK +: LINES_PER_BANK];
        typB = typ[b*LINES_PER_BANK +: LINES_PER_BANK];
      end
    end
  end

  always_comb begin
    strb      = '0;
    strb.bank = BANK_IDX_W'(bIdx);
    if (wrEn) begin
      if (isGlobal) begin
        strb.masterWr = (addr[3:0] == 4'(A_MASTER));
        strb.outEnWr  = (addr[3:0] == 4'(A_OUTEN));
      end else if (inRange) begin
        strb.enSetWr  = (sub == 3'(S_EN_SET));
        strb.enClrWr  = (sub == 3'(S_EN_CLR));
        strb.rawClrWr = (sub == 3'(S_RAW));
        strb.typeWr   = (sub == 3'(S_TYPE));
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (isGlobal) begin
        case (addr[3:0])
          4'(A_IDENT):  rdData = {VERSION, 16'(NUM_LINES)};
          4'(A_MASTER): rdData = {31'b0, masterEn};
          4'(A_MSTAT):  rdData = {31'b0, masterEn & anyPending};
          4'(A_OUTEN):  rdData = {31'b0, outEn};
          default:      rdData = '0;
        endcase
      end else if (inRange) begin
        case (sub)
          3'(S_EN_SET), 3'(S_EN_CLR): rdData = enB;
          3'(S_RAW):                  rdData = rawB;
          3'(S_TYPE):                 rdData = typB;
          3'(S_PENDING):              rdData = rawB & enB;
          default:                    rdData = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/bank_irq_datapath.sv
module bank_irq_datapath
  import bank_irq_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strb,
  input  logic [31:0]          wrData,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic [NUM_LINES-1:0] en,
  output logic [NUM_LINES-1:0] raw,
  output logic [NUM_LINES-1:0] typ,
  output logic                 masterEn,
  output logic                 outEn,
  output logic                 anyPending,
  output logic                 irqOut
);
  localparam int NUM_BANKS = NUM_LINES / LINES_PER_BANK;

  logic [NUM_LINES-1:0] enSetM, enClrM, rawClrM, typSel, typData;
  logic [NUM_LINES-1:0] inPrev, rawSet;

  always_comb begin
    enSetM  = '0;
    enClrM  = '0;
    rawClrM = '0;
    typSel  = '0;
    typData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strb.bank == BANK_IDX_W'(b)) begin
        enSetM[b*LINES_PER_BANK +: LINES_PER_BANK]  = strb.enSetWr  ? wrData : '0;
        enClrM[b*LINES_PER_BANK +: LINES_PER_BANK]  = strb.enClrWr  ? wrData : '0;
        rawClrM[b*LINES_PER_BANK +: LINES_PER_BANK] = strb.rawClrWr ? wrData : '0;
        typSel[b*LINES_PER_BANK +: LINES_PER_BANK]  = {LINES_PER_BANK{strb.typeWr}};
        typData[b*LINES_PER_BANK +: LINES_PER_BANK] = wrData;
      end
    end
    // level lines set while high, edge lines on a rising transition
    rawSet     = (~typ & irqIn) | (typ & irqIn & ~inPrev);
    anyPending = |(raw & en);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en       <= '0;
      raw      <= '0;
      typ      <= '0;
      inPrev   <= '0;
      masterEn <= 1'b0;
      outEn    <= 1'b1;
      irqOut   <= 1'b0;
    end else begin
      en       <= (en | enSetM) & ~enClrM;
      raw      <= rawSet | (raw & ~rawClrM);
      typ      <= (typ & ~typSel) | (typData & typSel);
      inPrev   <= irqIn;
      if (strb.masterWr) masterEn <= wrData[0];
      if (strb.outEnWr)  outEn    <= wrData[0];
      irqOut   <= masterEn & outEn & anyPending;
    end
  end
endmodule

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl
  import bank_irq_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 8,
  parameter logic [15:0] VERSION = 16'h0102
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdData,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic                 irqOut
);
  ctlStrobes_t          strb;
  logic [NUM_LINES-1:0] en, raw, typ;
  logic                 masterEn, outEn, anyPending;

  bank_irq_decode #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .VERSION(VERSION)) u_decode (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .en(en), .raw(raw), .typ(typ),
    .masterEn(masterEn), .outEn(outEn), .anyPending(anyPending),
    .strb(strb), .rdData(rdData)
  );

  bank_irq_datapath #(.NUM_LINES(NUM_LINES)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .irqIn(irqIn),
    .en(en), .raw(raw), .typ(typ), .masterEn(masterEn), .outEn(outEn),
    .anyPending(anyPending), .irqOut(irqOut)
  );
endmodule

// File: rtl/bank_irq_checker.sv
module bank_irq_checker #(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 8,
  parameter logic [15:0] VERSION = 16'h0102
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rdEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [31:0]          rdData,
  input logic [NUM_LINES-1:0] irqIn,
  input logic                 irqOut,
  input logic [NUM_LINES-1:0] raw,
  input logic [NUM_LINES-1:0] typ,
  input logic                 masterEn,
  input logic                 outEn,
  input logic                 anyPending,
  input logic                 rawClrWr
);
  AST_IDENT_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == '0) |-> (rdData == {VERSION, 16'(NUM_LINES)})); // R1

  AST_RAW_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !rawClrWr |=> ((raw & $past(raw)) == $past(raw))); // R4

  AST_LEVEL_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (|(irqIn & ~typ)) |=> ((($past(irqIn) & ~$past(typ)) & ~raw) == '0)); // R6

  AST_OUT_NEEDS_GATES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(masterEn && outEn && anyPending)); // R9

  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (masterEn && outEn && anyPending) |=> irqOut); // R9

  AST_OUT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |=> !irqOut); // R9
endmodule

bind bank_irq_ctrl bank_irq_checker #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .VERSION(VERSION)) u_checker (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .addr(addr), .rdData(rdData), .irqIn(irqIn),
  .irqOut(irqOut), .raw(raw), .typ(typ), .masterEn(masterEn), .outEn(outEn),
  .anyPending(anyPending), .rawClrWr(strb.rawClrWr)
);

// File: tb/bank_irq_ctrl_bench.sv
module bank_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 64;
  localparam int NB = NL / 32;
  localparam int AW = 8;
  localparam logic [15:0] VER = 16'h0102;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [NL-1:0] irqIn = '0;
  logic          irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit live = 0;

  // behavioural reference state
  bit mRaw[NL], mEn[NL], mTyp[NL], mPrev[NL];
  bit mMaster, mOe, mIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_irq_ctrl #(.NUM_LINES(NL), .ADDR_W(AW), .VERSION(VER)) u_bank_irq_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqIn(irqIn), .irqOut(irqOut)
  );

  function automatic bit anyPend();
    for (int i = 0; i < NL; i++) if (mRaw[i] && mEn[i]) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] modelRead(int a);
    logic [31:0] v = '0;
    int b, s;
    if (a == 0) return {VER, 16'(NL)};
    if (a == 1) return {31'b0, mMaster};
    if (a == 2) return {31'b0, mMaster & anyPend()};
    if (a == 3) return {31'b0, mOe};
    if (a < 16) return '0;
    b = (a - 16) / 8;
    s = (a - 16) % 8;
    if (b >= NB) return '0;
    for (int k = 0; k < 32; k++) begin
      case (s)
        0, 1: v[k] = mEn[b*32+k];
        2: v[k] = mRaw[b*32+k];
        3: v[k] = mTyp[b*32+k];
        4: v[k] = mRaw[b*32+k] & mEn[b*32+k];
        default: v[k] = 1'b0;
      endcase
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NL; i++) begin
        mRaw[i] = 0; mEn[i] = 0; mTyp[i] = 0; mPrev[i] = 0;
      end
      mMaster = 0; mOe = 1; mIrq = 0;
    end else begin
      int a, b, s;
      bit nextIrq;
      bit setEv, clrBit;
      a = int'(addr);
      nextIrq = mMaster && mOe && anyPend();
      b = (a - 16) / 8;
      s = (a - 16) % 8;
      for (int i = 0; i < NL; i++) begin
        setEv  = mTyp[i] ? (irqIn[i] && !mPrev[i]) : irqIn[i];
        clrBit = wrEn && a >= 16 && b < NB && s == 2 && (i / 32) == b && wrData[i % 32];
        mRaw[i]  = setEv || (mRaw[i] && !clrBit);
        mPrev[i] = irqIn[i];
      end
      if (wrEn) begin
        if (a == 1) mMaster = wrData[0];
        if (a == 3) mOe = wrData[0];
        if (a >= 16 && b < NB) begin
          for (int k = 0; k < 32; k++) begin
            if (s == 0 && wrData[k]) mEn[b*32+k] = 1;
            if (s == 1 && wrData[k]) mEn[b*32+k] = 0;
            if (s == 3) mTyp[b*32+k] = wrData[k];
          end
        end
      end
      mIrq = nextIrq;
    end
  end

  // per-cycle output comparison, R9
  always @(negedge clk) begin
    if (live && !done) begin
      checks++;
      if (irqOut !== mIrq) begin
        errors++;
        $display("FAIL R9 irqOut at %0t: actual %0b expected %0b", $time, irqOut, mIrq);
      end
    end
  end

  task automatic writeReg(int a, logic [31:0] d);
    @(negedge clk);
    rdEn = 0; wrEn = 1; addr = AW'(a); wrData = d;
    @(negedge clk);
    wrEn = 0; wrData = '0;
  endtask

  task automatic readReg(int a, string tag);
    logic [31:0] exp;
    @(negedge clk);
    wrEn = 0; rdEn = 1; addr = AW'(a);
    #1;
    exp = modelRead(a);
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s read addr %0d: actual %h expected %h", tag, a, rdData, exp);
    end
    rdEn = 0;
  endtask

  task automatic checkVal(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    live = 1;
    // reset state
    readReg(0, "R1");
    checkVal(rdData, {VER, 16'd64}, "R1 ident fixed");
    readReg(1, "R8");
    readReg(3, "R9");
    readReg(16, "R2");
    readReg(24, "R2");
    readReg(19, "R5");
    // enable set / clear
    writeReg(16, 32'h0000_00FF);
    readReg(16, "R2");
    checkVal(rdData, 32'h0000_00FF, "R2 enable mask");
    writeReg(16, 32'h0);
    readReg(16, "R2");
    writeReg(24, 32'h8000_0001);
    readReg(24, "R2");
    writeReg(17, 32'h0000_000F);
    readReg(17, "R3");
    checkVal(rdData, 32'h0000_00F0, "R3 after clear");
    writeReg(17, 32'h0);
    readReg(16, "R3");
    // level latching with master off
    @(negedge clk); irqIn[4] = 1;
    idle(2);
    irqIn[4] = 0;
    idle(2);
    readReg(18, "R4");
    checkVal(rdData, 32'h0000_0010, "R4 raw latched");
    readReg(20, "R7");
    readReg(2, "R8");
    // master on -> output
    writeReg(1, 32'h1);
    idle(2);
    readReg(2, "R8");
    checkVal({31'b0, irqOut}, 32'h1, "R9 irqOut asserted");
    // output enable masks without losing status
    writeReg(3, 32'h0);
    idle(2);
    checkVal({31'b0, irqOut}, 32'h0, "R9 masked");
    readReg(18, "R9");
    writeReg(3, 32'h1);
    idle(2);
    checkVal({31'b0, irqOut}, 32'h1, "R9 reasserted");
    // writes to pending register ignored
    writeReg(20, 32'hFFFF_FFFF);
    readReg(20, "R7");
    readReg(16, "R7");
    // clear raw
    writeReg(18, 32'hFFFF_FFFF);
    idle(2);
    readReg(18, "R4");
    checkVal({31'b0, irqOut}, 32'h0, "R4 irqOut after clear");
    // edge mode on bank 1 line 0 (line 32), held high across clear
    writeReg(27, 32'h0000_0001);
    readReg(27, "R5");
    @(negedge clk); irqIn[32] = 1;
    idle(2);
    readReg(26, "R5");
    checkVal(rdData, 32'h0000_0001, "R5 edge captured");
    writeReg(26, 32'h0000_0001);
    idle(2);
    readReg(26, "R5");
    checkVal(rdData, 32'h0, "R5 no recapture while high");
    // unenabled edge line 33: rising edge sets raw, pending unaffected
    writeReg(27, 32'h0000_0003);
    @(negedge clk); irqIn[33] = 1;
    idle(1);
    readReg(28, "R7");
    irqIn[32] = 0; irqIn[33] = 0;
    // set wins over clear on level line 5
    @(negedge clk); irqIn[5] = 1;
    writeReg(18, 32'h0000_0020);
    readReg(18, "R6");
    checkVal(rdData & 32'h20, 32'h20, "R6 set wins");
    irqIn[5] = 0;
    writeReg(18, 32'h0000_0020);
    readReg(18, "R6");
    // out-of-range bank
    writeReg(32, 32'hFFFF_FFFF);
    writeReg(35, 32'hFFFF_FFFF);
    readReg(32, "R10");
    checkVal(rdData, 32'h0, "R10 read zero");
    readReg(16, "R10");
    readReg(24, "R10");
    readReg(27, "R10");
    // master off drops output
    writeReg(16, 32'h0000_0100);
    @(negedge clk); irqIn[8] = 1;
    idle(3);
    writeReg(1, 32'h0);
    idle(2);
    checkVal({31'b0, irqOut}, 32'h0, "R8 master off");
    readReg(2, "R8");
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule